// File: doc/BRIEF.md
# Scancode-Driven Keyboard Matrix Emulator

This block stands in for the passive 8-row by 6-column key matrix of a vintage 8-bit computer. A host keyboard front end delivers decoded scancode events, one per cycle at most, each carrying a pressed/released flag and an extended-key flag. The block keeps one bit per matrix position, where 1 means released and 0 means pressed. It also keeps a small register of host-only keys: right shift, both alt keys, escape, backspace and the four arrows. These host-only keys are turned into presses of existing matrix keys. Most of them form a chord, in which a target key is pressed together with control.

The CPU reads the matrix through a memory window. Each of the low eight address bits that is 0 selects one row. When several rows are selected, their column data is combined with a bitwise AND. The returned byte is captured on the CPU bus-cycle strobe and holds until the next strobe that hits the window, so the CPU samples a steady value. A key-down output reports whether any of the 64 stored matrix bits is pressed.

Top module: `kbd_matrix_emu`

## Requirements
- R1: After reset, all 64 matrix bits and all host-key bits are released, `key_down` is 0, and `rd_data` is 0xFF.
- R2: `rd_data` loads on a rising clock edge only when `bus_strobe` is 1 and `bus_addr[15:11]` is 5'b01101. Address bits 10..8 do not affect the result. A strobe outside the window leaves `rd_data` unchanged. An event presented in the same cycle as the strobe is not visible in that read.
- R3: Bit 7 of a loaded read is 1. Bit 6 is the inverse of `cass_in`, sampled at the strobe edge.
- R4: Bit c (0..5) of a loaded read is the AND of effective matrix bit 8*r+c over every row r whose `bus_addr[r]` is 0. When no row is selected, bits 5..0 are all 1.
- R5: An event whose code is a matrix key writes the inverse of `evt_pressed` into that key's bit 8*r+c. The bench relies on these codes: 0x2C→0, 0x15→4, 0x1C→12, 0x14→10 (control), 0x12→18 (shift), 0x16→28, 0x31→32, 0x29→36, 0x3A→37, 0x5A→50, 0x4D→52, 0x33→56. A code with no mapping, such as 0x00, changes nothing.
- R6: Codes 0x75 (up), 0x72 (down), 0x6B (left), 0x74 (right), 0x76 (escape) and 0x66 (backspace) set host-key bits. While held, each one forces a matrix position low: up→33, down→36, left→37, right→35, escape→42, backspace→37. Control (10) is also forced low whenever any of them is held.
- R7: Code 0x11 with `evt_extended` 0 is left alt, which forces control (10) low. With `evt_extended` 1 it is right alt, which forces return (50) and control (10) low. The two variants are stored and released independently.
- R8: Code 0x59 (right shift) drives the shift position (18) through its own storage bit. Releasing one shift while the other is still held keeps position 18 low.
- R9: `key_down` is 1 exactly when at least one of the 64 stored matrix bits is 0. Host-only keys do not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | A scancode event is present this cycle |
| evt_code | input | 8 | Scancode of the event |
| evt_pressed | input | 1 | 1 for a key press, 0 for a release |
| evt_extended | input | 1 | Extended-key flag of the event |
| bus_strobe | input | 1 | CPU bus-cycle strobe that captures read data |
| bus_addr | input | 16 | CPU address |
| cass_in | input | 1 | Cassette input level |
| rd_data | output | 8 | Registered matrix read byte |
| key_down | output | 1 | Some matrix key is held |

## Verification
The embedded properties check, on every cycle, that a mapped event lands in its matrix bit on the next edge and that the matrix is frozen between events. They also check that bit 7 stays high, that bit 6 follows the inverted cassette level, that a strobe outside the window holds the read byte, and that `key_down` only rises after a press event. The AND of several selected rows, the chord forcing of control, the interaction of the two shift bits and the separation of the two alt keys can only be shown by the bench. The bench compares each read against a reference model of the matrix under directed and random row selections.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
    localparam int ROWS    = 8;
    localparam int STRIDE  = 8;
    localparam int COLS    = 6;
    localparam int NBITS   = ROWS * STRIDE;
    localparam int IDX_W   = $clog2(NBITS);
    localparam int EXT_W   = 9;
    localparam int EXT_IW  = $clog2(EXT_W);
    localparam int ADDR_W  = 16;
    localparam int WIN_W   = 5;
    localparam logic [WIN_W-1:0] WIN_TAG = 5'b01101;

    // host-key register slots
    localparam int HK_RSHIFT = 0;
    localparam int HK_ALT_L  = 1;
    localparam int HK_ALT_R  = 2;
    localparam int HK_ESC    = 3;
    localparam int HK_UP     = 4;
    localparam int HK_LEFT   = 5;
    localparam int HK_RIGHT  = 6;
    localparam int HK_DOWN   = 7;
    localparam int HK_BKSP   = 8;
    localparam int HK_CHORD_LO = HK_ALT_R;

    // matrix positions targeted by host keys
    localparam int POS_CTRL   = 10;
    localparam int POS_SHIFT  = 18;
    localparam int POS_DOT    = 33;
    localparam int POS_COMMA  = 35;
    localparam int POS_SPACE  = 36;
    localparam int POS_M      = 37;
    localparam int POS_MINUS  = 42;
    localparam int POS_RETURN = 50;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } key_slot_t;

    typedef struct packed {
        logic              hit;
        logic [EXT_IW-1:0] idx;
    } host_slot_t;

    function automatic key_slot_t mk(input int pos);
        key_slot_t s;
        s.hit = 1'b1;
        s.idx = IDX_W'(pos);
        return s;
    endfunction

    function automatic key_slot_t key_lookup(input logic [7:0] code);
        key_slot_t s;
        s = '0;
        case (code)
            8'h12: s = mk(18);
            8'h14: s = mk(10);
            8'h15: s = mk(4);
            8'h16: s = mk(28);
            8'h1A: s = mk(20);
            8'h1B: s = mk(9);
            8'h1C: s = mk(12);
            8'h1D: s = mk(1);
            8'h1E: s = mk(25);
            8'h21: s = mk(19);
            8'h22: s = mk(17);
            8'h23: s = mk(11);
            8'h24: s = mk(3);
            8'h25: s = mk(29);
            8'h26: s = mk(27);
            8'h29: s = mk(36);
            8'h2A: s = mk(21);
            8'h2B: s = mk(13);
            8'h2C: s = mk(0);
            8'h2D: s = mk(5);
            8'h2E: s = mk(24);
            8'h31: s = mk(32);
            8'h32: s = mk(16);
            8'h33: s = mk(56);
            8'h34: s = mk(8);
            8'h35: s = mk(48);
            8'h36: s = mk(40);
            8'h3A: s = mk(37);
            8'h3B: s = mk(61);
            8'h3C: s = mk(53);
            8'h3D: s = mk(45);
            8'h3E: s = mk(43);
            8'h41: s = mk(35);
            8'h42: s = mk(59);
            8'h43: s = mk(51);
            8'h44: s = mk(49);
            8'h45: s = mk(44);
            8'h46: s = mk(41);
            8'h49: s = mk(33);
            8'h4B: s = mk(57);
            8'h4C: s = mk(60);
            8'h4D: s = mk(52);
            8'h4E: s = mk(42);
            8'h52: s = mk(58);
            8'h5A: s = mk(50);
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic host_slot_t host_lookup(input logic [7:0] code,
                                               input logic       ext);
        host_slot_t s;
        s.hit = 1'b1;
        s.idx = '0;
        case (code)
            8'h59: s.idx = EXT_IW'(HK_RSHIFT);
            8'h11: s.idx = ext ? EXT_IW'(HK_ALT_R) : EXT_IW'(HK_ALT_L);
            8'h76: s.idx = EXT_IW'(HK_ESC);
            8'h75: s.idx = EXT_IW'(HK_UP);
            8'h6B: s.idx = EXT_IW'(HK_LEFT);
            8'h74: s.idx = EXT_IW'(HK_RIGHT);
            8'h72: s.idx = EXT_IW'(HK_DOWN);
            8'h66: s.idx = EXT_IW'(HK_BKSP);
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/kbm_store.sv
module kbm_store
    import kbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [7:0]       evt_code,
    input  logic             evt_pressed,
    input  logic             evt_extended,
    output logic [NBITS-1:0] keys,
    output logic [EXT_W-1:0] hkeys
);
    typedef struct packed {
        logic [NBITS-1:0] keys;
        logic [EXT_W-1:0] hk;
    } store_t;

    store_t     st_d, st_q;
    key_slot_t  ks;
    host_slot_t hs;

    always_comb begin
        ks   = key_lookup(evt_code);
        hs   = host_lookup(evt_code, evt_extended);
        st_d = st_q;
        if (evt_valid) begin
            if (ks.hit) begin
                st_d.keys[ks.idx] = ~evt_pressed;
            end else if (hs.hit) begin
                st_d.hk[hs.idx] = ~evt_pressed;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign keys  = st_q.keys;
    assign hkeys = st_q.hk;

    p_key_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && ks.hit) |=> (keys[$past(ks.idx)] == !$past(evt_pressed)));

    p_idle_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> ($stable(keys) && $stable(hkeys)));
endmodule

// File: rtl/kbm_chord.sv
module kbm_chord
    import kbm_pkg::*;
(
    input  logic [NBITS-1:0] keys,
    input  logic [EXT_W-1:0] hkeys,
    output logic [NBITS-1:0] eff
);
    logic [NBITS-1:0] force_d;
    logic             chord_any;

    always_comb begin
        chord_any = ~&hkeys[EXT_W-1:HK_CHORD_LO];
        force_d   = '0;
        force_d[POS_SHIFT]  = ~hkeys[HK_RSHIFT];
        force_d[POS_RETURN] = ~hkeys[HK_ALT_R];
        force_d[POS_MINUS]  = ~hkeys[HK_ESC];
        force_d[POS_DOT]    = ~hkeys[HK_UP];
        force_d[POS_COMMA]  = ~hkeys[HK_RIGHT];
        force_d[POS_SPACE]  = ~hkeys[HK_DOWN];
        force_d[POS_M]      = ~hkeys[HK_LEFT] | ~hkeys[HK_BKSP];
        force_d[POS_CTRL]   = ~hkeys[HK_ALT_L] | chord_any;
        eff = keys & ~force_d;
    end
endmodule

// File: rtl/kbm_reader.sv
module kbm_reader
    import kbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              cass_in,
    input  logic [NBITS-1:0]  eff,
    output logic [7:0]        rd_data
);
    logic [COLS-1:0] col_d;
    logic            win_hit;
    logic [7:0]      rd_d, rd_q;

    always_comb begin
        win_hit = (bus_addr[ADDR_W-1 -: WIN_W] == WIN_TAG);
        for (int c = 0; c < COLS; c++) begin
            col_d[c] = 1'b1;
            for (int r = 0; r < ROWS; r++) begin
                if (!bus_addr[r]) begin
                    col_d[c] = col_d[c] & eff[r*STRIDE + c];
                end
            end
        end
        rd_d = rd_q;
        if (bus_strobe && win_hit) begin
            rd_d = {1'b1, ~cass_in, col_d};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 8'hFF;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

    p_top_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b1);

    p_cass_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && win_hit) |=> (rd_data[6] == !$past(cass_in)));

    p_out_of_window_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_strobe && win_hit) |=> $stable(rd_data));
endmodule

// File: rtl/kbd_matrix_emu.sv
module kbd_matrix_emu
    import kbm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt_valid,
    input  logic [7:0]  evt_code,
    input  logic        evt_pressed,
    input  logic        evt_extended,
    input  logic        bus_strobe,
    input  logic [15:0] bus_addr,
    input  logic        cass_in,
    output logic [7:0]  rd_data,
    output logic        key_down
);
    logic [NBITS-1:0] keys;
    logic [EXT_W-1:0] hkeys;
    logic [NBITS-1:0] eff;

    kbm_store u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_valid    (evt_valid),
        .evt_code     (evt_code),
        .evt_pressed  (evt_pressed),
        .evt_extended (evt_extended),
        .keys         (keys),
        .hkeys        (hkeys)
    );

    kbm_chord u_chord (
        .keys  (keys),
        .hkeys (hkeys),
        .eff   (eff)
    );

    kbm_reader u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_strobe (bus_strobe),
        .bus_addr   (bus_addr),
        .cass_in    (cass_in),
        .eff        (eff),
        .rd_data    (rd_data)
    );

    assign key_down = ~&keys;

    p_down_needs_press_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_down) |-> $past(evt_valid && evt_pressed));
endmodule

// File: tb/kbd_matrix_emu_tb.sv
module kbd_matrix_emu_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_code = '0;
    logic        evt_pressed = 1'b0;
    logic        evt_extended = 1'b0;
    logic        bus_strobe = 1'b0;
    logic [15:0] bus_addr = 16'hFFFF;
    logic        cass_in = 1'b0;
    logic [7:0]  rd_data;
    logic        key_down;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_keys = '1;
    logic [8:0]  m_hk   = '1;

    kbd_matrix_emu u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
        .evt_pressed(evt_pressed), .evt_extended(evt_extended),
        .bus_strobe(bus_strobe), .bus_addr(bus_addr), .cass_in(cass_in),
        .rd_data(rd_data), .key_down(key_down)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // bench reference: matrix position of a code, -1 when not a matrix key
    function automatic int ref_pos(input logic [7:0] code);
        case (code)
            8'h2C: return 0;   8'h15: return 4;   8'h1C: return 12;
            8'h14: return 10;  8'h12: return 18;  8'h16: return 28;
            8'h31: return 32;  8'h29: return 36;  8'h3A: return 37;
            8'h5A: return 50;  8'h4D: return 52;  8'h33: return 56;
            default: return -1;
        endcase
    endfunction

    // host-key slot, -1 when none
    function automatic int ref_host(input logic [7:0] code, input logic ext);
        case (code)
            8'h59: return 0;
            8'h11: return ext ? 2 : 1;
            8'h76: return 3;
            8'h75: return 4;
            8'h6B: return 5;
            8'h74: return 6;
            8'h72: return 7;
            8'h66: return 8;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] ref_read(input logic [7:0] low, input logic cass);
        logic [63:0] e;
        logic [5:0]  cols;
        bit chord;
        e = m_keys;
        chord = 0;
        if (!m_hk[0]) e[18] = 0;
        if (!m_hk[1]) e[10] = 0;
        if (!m_hk[2]) begin e[50] = 0; chord = 1; end
        if (!m_hk[3]) begin e[42] = 0; chord = 1; end
        if (!m_hk[4]) begin e[33] = 0; chord = 1; end
        if (!m_hk[5]) begin e[37] = 0; chord = 1; end
        if (!m_hk[6]) begin e[35] = 0; chord = 1; end
        if (!m_hk[7]) begin e[36] = 0; chord = 1; end
        if (!m_hk[8]) begin e[37] = 0; chord = 1; end
        if (chord) e[10] = 0;
        cols = '1;
        for (int r = 0; r < 8; r++)
            if (!low[r])
                for (int c = 0; c < 6; c++)
                    if (!e[r*8+c]) cols[c] = 0;
        return {1'b1, ~cass, cols};
    endfunction

    task automatic model_evt(input logic [7:0] code, input logic pr, input logic ext);
        int p, h;
        p = ref_pos(code);
        h = ref_host(code, ext);
        if (p >= 0) m_keys[p] = ~pr;
        else if (h >= 0) m_hk[h] = ~pr;
    endtask

    task automatic send(input logic [7:0] code, input logic pr, input logic ext);
        @(negedge clk);
        evt_valid = 1; evt_code = code; evt_pressed = pr; evt_extended = ext;
        @(negedge clk);
        evt_valid = 0;
        model_evt(code, pr, ext);
    endtask

    // read through the window and compare with the model
    task automatic rd_chk(input logic [15:0] a, input logic cass, input string tag);
        logic [7:0] prev, exp;
        bit hit;
        @(negedge clk);
        prev = rd_data;
        hit = (a[15:11] == 5'b01101);
        exp = hit ? ref_read(a[7:0], cass) : prev;
        bus_strobe = 1; bus_addr = a; cass_in = cass;
        @(negedge clk);
        bus_strobe = 0;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic kd_chk(input string tag);
        logic e;
        e = (m_keys != '1);
        chk(key_down == e, tag, key_down, e);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] pool [21];
        logic [7:0] hold;
        pool = '{8'h1C, 8'h2C, 8'h15, 8'h16, 8'h5A, 8'h29, 8'h33, 8'h4D, 8'h14,
                 8'h12, 8'h31, 8'h3A, 8'h75, 8'h72, 8'h6B, 8'h74, 8'h76, 8'h66,
                 8'h11, 8'h59, 8'h00};
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk(rd_data == 8'hFF, "R1 rd_data", rd_data, 8'hFF);
        chk(key_down == 0, "R1 key_down", key_down, 0);
        rd_chk(16'h6800, 1'b0, "R1 all rows released");
        rd_chk(16'h6800, 1'b1, "R3 cassette high");

        // R5/R9: single key press
        send(8'h1C, 1, 0);
        kd_chk("R9 key_down after press");
        rd_chk(16'h68FD, 1'b0, "R5 row1 key A");
        rd_chk(16'h6FFD, 1'b0, "R2 bits 10..8 ignored");
        hold = rd_data;
        rd_chk(16'h78FE, 1'b1, "R2 outside window holds");
        chk(rd_data == hold, "R2 hold value", rd_data, hold);

        // R4: several rows combined
        send(8'h2C, 1, 0);
        rd_chk(16'h68FC, 1'b0, "R4 rows 0 and 1 ANDed");
        rd_chk(16'h68FE, 1'b0, "R4 row0 only");
        rd_chk(16'h68FF, 1'b0, "R4 no row selected");

        // R5: unknown code and release
        send(8'h00, 1, 0);
        rd_chk(16'h6800, 1'b0, "R5 unknown code ignored");
        send(8'h1C, 0, 0);
        send(8'h2C, 0, 0);
        kd_chk("R9 key_down after release");

        // R6: chords
        send(8'h75, 1, 1);
        kd_chk("R9 host key not counted");
        rd_chk(16'h68EF, 1'b0, "R6 up forces dot");
        rd_chk(16'h68FD, 1'b0, "R6 up forces control");
        send(8'h76, 1, 1);
        send(8'h75, 0, 1);
        rd_chk(16'h68DD, 1'b0, "R6 escape chord");
        send(8'h76, 0, 1);
        rd_chk(16'h6800, 1'b0, "R6 chord released");

        // R7: alt variants
        send(8'h11, 1, 0);
        rd_chk(16'h68BD, 1'b0, "R7 left alt control only");
        send(8'h11, 1, 1);
        rd_chk(16'h68BD, 1'b0, "R7 right alt return");
        send(8'h11, 0, 0);
        rd_chk(16'h68BD, 1'b0, "R7 left released right held");
        send(8'h11, 0, 1);
        rd_chk(16'h68BD, 1'b0, "R7 both released");

        // R8: two shift bits
        send(8'h12, 1, 0);
        send(8'h59, 1, 0);
        send(8'h12, 0, 0);
        rd_chk(16'h68FB, 1'b0, "R8 right shift keeps shift low");
        send(8'h59, 0, 0);
        rd_chk(16'h68FB, 1'b0, "R8 both shifts released");

        // R2: event in the same cycle as the strobe
        @(negedge clk);
        begin
            logic [7:0] exp;
            exp = ref_read(8'hF7, 1'b0);
            evt_valid = 1; evt_code = 8'h16; evt_pressed = 1; evt_extended = 0;
            bus_strobe = 1; bus_addr = 16'h68F7; cass_in = 0;
            @(negedge clk);
            evt_valid = 0; bus_strobe = 0;
            model_evt(8'h16, 1, 0);
            chk(rd_data == exp, "R2 same-cycle event not seen", rd_data, exp);
        end
        rd_chk(16'h68F7, 1'b0, "R5 key 1 visible next read");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  code, low;
            logic [15:0] a;
            code = pool[$urandom_range(0, 20)];
            send(code, 1'($urandom), 1'($urandom));
            kd_chk("R9 random");
            low = 8'($urandom | $urandom);
            if ($urandom_range(0, 9) == 0) low = 8'hFF;
            a = {5'b01101, 3'($urandom), low};
            if ($urandom_range(0, 7) == 0) a[15:11] = 5'($urandom);
            rd_chk(a, 1'($urandom), "R4 random read");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule